// File: doc/BRIEF.md
# LCD Common and Segment Level Sequencer

This block steps through the phases of a multiplexed passive LCD frame and emits, for every common line and every segment line, a 3-bit code that names the voltage fraction of the panel supply the analog stage must apply. A frame has one phase per active common line. A single-cycle phase enable advances the phase, and the block wraps the phase counter at the end of each frame. Each wrap flips a frame-parity bit, so the polarity of the whole drive pattern alternates from frame to frame and the panel sees no net DC.

A common line is driven to a rail only in its own phase. In every other phase it sits at an intermediate level set by the bias. A segment line is driven against the rail of the selected common line when its pixel is on, and to an off level when the pixel is off. The bias and duty selections are sampled at reset and at every frame boundary. A change made in the middle of a frame therefore never produces a partial frame.

Top module: `lcd_com_seq`

## Requirements
- R1: A synchronous reset sets the phase to 0 and the parity to even, and loads the bias and duty selections.
- R2: The phase advances by one on each clock where `ph_en` is high, and holds otherwise.
- R3: The frame has 1, 2, 3, 4 or 8 phases for duty codes 000, 001, 010, 011 and 100, and 4 phases for any other code. When `ph_en` is high in the last phase, the phase returns to 0 and the parity toggles. The parity changes at no other time.
- R4: Level codes are 0 for VSS, 1 for 1/4, 2 for 1/2, 3 for 3/4, 4 for VLCD, 5 for 1/3 and 6 for 2/3 of VLCD. The common line whose index equals the phase is driven to code 4 in even frames and to code 0 in odd frames.
- R5: Every other common line carries the idle level for the bias. Quarter bias gives 1 when even and 3 when odd. Third bias gives 5 when even and 6 when odd. Half bias gives 2.
- R6: Common lines with an index of at least the phase count are always at the idle level, so exactly one common line is at a rail at any time.
- R7: Bias code 00 selects quarter bias, 01 selects half bias, 10 selects third bias, and 11 behaves as quarter bias.
- R8: For duties other than static, a segment with `seg_pix` bit 1 (pixel on) is driven to 0 when even and 4 when odd. An off segment is driven to 2 under quarter bias, to 6 when even and 5 when odd under third bias, and to 4 when even and 0 when odd under half bias.
- R9: In static duty, common line 0 is 4 in even frames and 0 in odd frames. A segment is the opposite rail of common line 0 when on, and equal to common line 0 when off.
- R10: Bias and duty changes applied during a frame do not affect any output until the phase wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_en | input | 1 | Single-cycle phase advance enable |
| bias_sel | input | 2 | Requested bias code |
| duty_sel | input | 3 | Requested duty code |
| seg_pix | input | NUM_SEG | Pixel state of each segment for the current phase, 1 = on |
| com_lvl | output | 24 | Level code of each common line, line i at bits 3i+2..3i |
| seg_lvl | output | 3*NUM_SEG | Level code of each segment line, segment j at bits 3j+2..3j |
| phase | output | 3 | Current phase index |
| odd_frame | output | 1 | Frame parity, 1 in odd frames |

## Verification
The embedded properties check on every cycle that the phase holds without an enable and stays within the duty's range. They also check that a wrap clears the phase and flips the parity, that the parity and the active configuration change only at a wrap, and that exactly one common line sits at a rail. The actual level code on each line under each bias, parity, duty and pixel pattern can only be shown by the bench's scenarios, as can the deferral of a mid-frame configuration change and the static-duty segment relation.

// File: rtl/lcd_com_seq.sv
module lcd_com_seq #(
  parameter int NUM_SEG = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ph_en,
  input  logic [1:0]             bias_sel,
  input  logic [2:0]             duty_sel,
  input  logic [NUM_SEG-1:0]     seg_pix,
  output logic [23:0]            com_lvl,
  output logic [3*NUM_SEG-1:0]   seg_lvl,
  output logic [2:0]             phase,
  output logic                   odd_frame
);
  localparam int NUM_COM = 8;
  localparam int PH_W    = $clog2(NUM_COM);

  localparam logic [2:0] L_VSS = 3'd0, L_Q1 = 3'd1, L_HALF = 3'd2, L_Q3 = 3'd3,
                         L_VLCD = 3'd4, L_T1 = 3'd5, L_T2 = 3'd6;

  logic [1:0]      bias_q;
  logic [2:0]      duty_q;
  logic [PH_W-1:0] ph_q;
  logic            odd_q;
  logic [PH_W-1:0] last_ph;
  logic            wrap;
  logic [2:0]      lv_sel, lv_idle, lv_on, lv_off;

  always_comb begin
    case (duty_q)
      3'd0:    last_ph = PH_W'(0);
      3'd1:    last_ph = PH_W'(1);
      3'd2:    last_ph = PH_W'(2);
      3'd4:    last_ph = PH_W'(7);
      default: last_ph = PH_W'(3);
    endcase
  end

  assign wrap = ph_en && (ph_q == last_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      odd_q  <= 1'b0;
      bias_q <= bias_sel;
      duty_q <= duty_sel;
    end else if (wrap) begin
      ph_q   <= '0;
      odd_q  <= ~odd_q;
      bias_q <= bias_sel;
      duty_q <= duty_sel;
    end else if (ph_en) begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  assign lv_sel = odd_q ? L_VSS : L_VLCD;
  assign lv_on  = odd_q ? L_VLCD : L_VSS;

  always_comb begin
    case (bias_q)
      2'b01: begin
        lv_idle = L_HALF;
        lv_off  = odd_q ? L_VSS : L_VLCD;
      end
      2'b10: begin
        lv_idle = odd_q ? L_T2 : L_T1;
        lv_off  = odd_q ? L_T1 : L_T2;
      end
      default: begin
        lv_idle = odd_q ? L_Q3 : L_Q1;
        lv_off  = L_HALF;
      end
    endcase
    if (duty_q == 3'd0) lv_off = lv_sel;
  end

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign com_lvl[3*i +: 3] = (ph_q == PH_W'(i)) ? lv_sel : lv_idle;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    assign seg_lvl[3*j +: 3] = seg_pix[j] ? lv_on : lv_off;
  end

  assign phase     = ph_q;
  assign odd_frame = odd_q;

  logic [NUM_COM-1:0] at_rail;
  for (genvar i = 0; i < NUM_COM; i++) begin : g_rail
    assign at_rail[i] = (com_lvl[3*i +: 3] == L_VSS) || (com_lvl[3*i +: 3] == L_VLCD);
  end

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ph_en |=> $stable(phase));
  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    phase <= last_ph);
  p_wrap_flip_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase == '0) && (odd_frame != $past(odd_frame)));
  p_parity_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(odd_frame));
  p_one_rail_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(at_rail) == 1);
  p_cfg_frame_r10: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(bias_q) && $stable(duty_q));
endmodule

// File: tb/lcd_com_seq_test.sv
module lcd_com_seq_test;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic ph_en = 1'b0;
  logic [1:0] bias_sel = 2'b00;
  logic [2:0] duty_sel = 3'b011;
  logic [NS-1:0] seg_pix = '0;
  logic [23:0] com_lvl;
  logic [3*NS-1:0] seg_lvl;
  logic [2:0] phase;
  logic odd_frame;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  lcd_com_seq #(.NUM_SEG(NS)) uut (
    .clk(clk), .rst(rst), .ph_en(ph_en), .bias_sel(bias_sel), .duty_sel(duty_sel),
    .seg_pix(seg_pix), .com_lvl(com_lvl), .seg_lvl(seg_lvl), .phase(phase),
    .odd_frame(odd_frame)
  );

  always #5 clk = ~clk;

  // fields: bias, duty, ph_en pulses, pixels, expected phase, expected parity
  localparam logic [16:0] VEC [12] = '{
    {2'b00, 3'd3, 4'd0, 4'b1010, 3'd0, 1'b0},
    {2'b00, 3'd3, 4'd3, 4'b0101, 3'd3, 1'b0},
    {2'b00, 3'd3, 4'd5, 4'b1100, 3'd1, 1'b1},
    {2'b10, 3'd2, 4'd4, 4'b0011, 3'd1, 1'b1},
    {2'b01, 3'd1, 4'd3, 4'b1001, 3'd1, 1'b1},
    {2'b01, 3'd0, 4'd1, 4'b0110, 3'd0, 1'b1},
    {2'b00, 3'd0, 4'd2, 4'b1110, 3'd0, 1'b0},
    {2'b10, 3'd4, 4'd7, 4'b0001, 3'd7, 1'b0},
    {2'b10, 3'd4, 4'd9, 4'b1000, 3'd1, 1'b1},
    {2'b11, 3'd3, 4'd2, 4'b0111, 3'd2, 1'b0},
    {2'b00, 3'd6, 4'd4, 4'b1011, 3'd0, 1'b1},
    {2'b10, 3'd2, 4'd2, 4'b1101, 3'd2, 1'b0}
  };

  function automatic int nphases(input logic [2:0] d);
    case (d)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd4: return 8;
      default: return 4;
    endcase
  endfunction

  // R5, R7: idle level by bias
  function automatic logic [2:0] m_idle(input logic [1:0] b, input logic odd);
    if (b == 2'b01) return 3'd2;
    if (b == 2'b10) return odd ? 3'd6 : 3'd5;
    return odd ? 3'd3 : 3'd1;
  endfunction

  function automatic logic [2:0] m_com(input int i, input logic [1:0] b, input int ph, input logic odd);
    if (i == ph) return odd ? 3'd0 : 3'd4;
    return m_idle(b, odd);
  endfunction

  function automatic logic [2:0] m_seg(input logic on, input logic [1:0] b, input logic [2:0] d, input logic odd);
    logic [2:0] c0;
    c0 = odd ? 3'd0 : 3'd4;
    if (d == 3'd0) return on ? (3'd4 - c0) : c0;
    if (on) return odd ? 3'd4 : 3'd0;
    if (b == 2'b01) return odd ? 3'd0 : 3'd4;
    if (b == 2'b10) return odd ? 3'd5 : 3'd6;
    return 3'd2;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) ph_en = 1'b1;
    @(negedge clk) ph_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 12; v++) begin
      logic [1:0] b;
      logic [2:0] d;
      int steps;
      b = VEC[v][16:15];
      d = VEC[v][14:12];
      steps = int'(VEC[v][11:8]);
      bias_sel = b;
      duty_sel = d;
      seg_pix = VEC[v][7:4];
      do_reset();
      for (int s = 0; s < steps; s++) pulse();
      chk(phase, VEC[v][3:1], "R3 phase");
      chk(odd_frame, VEC[v][0], "R3 parity");
      for (int i = 0; i < 8; i++) begin
        int exp;
        exp = m_com(i, b, int'(phase), odd_frame);
        if (i >= nphases(d)) chk(com_lvl[3*i +: 3], exp, "R6 com beyond duty");
        else if (i == int'(VEC[v][3:1])) chk(com_lvl[3*i +: 3], exp, "R4 selected com");
        else chk(com_lvl[3*i +: 3], exp, "R5 idle com");
      end
      for (int j = 0; j < NS; j++) begin
        if (d == 3'd0) chk(seg_lvl[3*j +: 3], m_seg(seg_pix[j], b, d, odd_frame), "R9 static seg");
        else chk(seg_lvl[3*j +: 3], m_seg(seg_pix[j], b, d, odd_frame), "R8 seg");
      end
    end

    // R1: reset state
    bias_sel = 2'b00; duty_sel = 3'd3; seg_pix = 4'b0001;
    do_reset();
    chk(phase, 0, "R1 phase");
    chk(odd_frame, 0, "R1 parity");
    pulse();
    // R2: hold without enable
    repeat (5) @(negedge clk);
    chk(phase, 1, "R2 hold");
    // R10: mid-frame change deferred
    bias_sel = 2'b01; duty_sel = 3'd0;
    pulse();
    chk(phase, 2, "R10 old duty");
    chk(com_lvl[2:0], 1, "R10 old bias idle");
    chk(com_lvl[8:6], 4, "R10 selected");
    chk(seg_lvl[2:0], 0, "R10 old seg on");
    chk(seg_lvl[5:3], 2, "R10 old seg off");
    pulse();
    pulse();
    chk(phase, 0, "R10 wrap phase");
    chk(odd_frame, 1, "R10 wrap parity");
    chk(com_lvl[2:0], 0, "R9 static com0 odd");
    chk(com_lvl[5:3], 2, "R10 new bias idle");
    chk(seg_lvl[2:0], 4, "R9 static seg on");
    chk(seg_lvl[5:3], 0, "R9 static seg off");
    pulse();
    chk(phase, 0, "R3 static wrap");
    chk(odd_frame, 0, "R3 static parity");
    chk(com_lvl[2:0], 4, "R9 static com0 even");
    // R1: reset mid-frame
    bias_sel = 2'b10; duty_sel = 3'd4;
    do_reset();
    pulse(); pulse(); pulse();
    chk(phase, 3, "R2 advance");
    do_reset();
    chk(phase, 0, "R1 mid reset phase");
    chk(odd_frame, 0, "R1 mid reset parity");
    chk(com_lvl[5:3], 5, "R7 third bias idle");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule